// File: doc/BRIEF.md
# Single-Channel Memory-Mapped DMA Engine

This block copies a programmed number of elements from a source address to a destination address, with no processor involvement once it is started. Software sets it up through four 32-bit words on a simple peripheral bus: control/status, source pointer, destination pointer and transfer descriptor. Data moves through a bus master port that has only one request outstanding at a time. Each element is read, optionally widened from a byte to a word with zero or sign fill, optionally byte-reversed, and then written.

A transfer starts in one of two ways. In manual mode, software writes the descriptor while the engine is enabled and idle. In automatic mode, a rising edge on any interrupt request line that the mask enables starts it. The pointer registers double as working pointers. They advance as the transfer runs, so after a bus error they hold the address that failed. When a transfer completes, the engine can emit a one-cycle fence request so that later traffic is ordered behind it.

Top module: `dma_engine`

## Requirements
- R1: Word offsets are 0 control, 4 source, 8 destination and 12 descriptor. The control word reads {mask[15:0] at 31:16, done at 11, busy at 10, write error at 9, read error at 8, fence enable at 2, auto mode at 1, enable at 0}. Other control bits read 0. Descriptor bits 26:24 read 0. All words are 0 after reset.
- R2: In manual mode (bit 1 clear), writing the descriptor while enabled and idle starts a transfer and sets busy. With enable clear, such a write starts nothing.
- R3: Descriptor bits 23:0 give the element count. A count of 0 sets done at once and makes no bus access.
- R4: Descriptor bits 28:27 select the conversion. 00 copies a byte to a byte, written on its lane with a single-byte strobe. 01 widens a byte to a zero-filled word. 10 widens a byte to a sign-filled word. 11 copies a word to a word. A byte read takes the lane given by the address bits 1:0.
- R5: Descriptor bit 29 makes the source advance per element, and bit 30 does the same for the destination. The step is 1 for a byte access and 4 for a word access, chosen separately for each side. When a transfer ends, the pointer registers read the advanced addresses.
- R6: Descriptor bit 31 reverses the byte order of each word that is written. It has no effect on byte writes.
- R7: In auto mode, a rising edge on an irq line whose mask bit (control bit 16+i) is set starts a transfer. Edges on lines whose mask bit is clear, a line held high, and descriptor writes start nothing.
- R8: A read error stops the transfer with no further access. It clears busy and sets done and the read error flag. The source register keeps the faulting address.
- R9: A write error does the same with the write error flag. The destination register keeps the faulting address.
- R10: When fence enable is set, a transfer that completes without error produces exactly one fence_o pulse. A transfer that ends in an error produces none.
- R11: A control write with bit 11 clear clears done and both error flags. A control write with bit 11 set leaves them unchanged.
- R12: Clearing the enable bit during a transfer aborts it. Busy drops, done stays clear and no further bus access is made.
- R13: m_req stays asserted with a stable address and direction until m_ack or m_err arrives.
- R14: Writes to the source, destination and descriptor words while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Register access select |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Word offset bits 3:2 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Master request, held until response |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_be | output | 4 | Master byte strobes |
| m_rdata | input | 32 | Master read data |
| m_ack | input | 1 | Master access done |
| m_err | input | 1 | Master access failed |
| irq_i | input | NIRQ | Interrupt request lines for auto start |
| fence_o | output | 1 | One-cycle fence request at completion |

## Verification
The hardest cases to reach are a bus error partway through a transfer and an abort while a request is pending. The bench's memory model faults every read above 0xF0000000 and every write in the 0xE0000000 range. It places source or destination pointers a few elements below such a boundary, so that several elements succeed before the failing access. Random response latencies and random conversion, increment and swap settings are checked against a reference copy of memory. A long constant-address transfer gives a window in which the enable bit can be cleared and locked-out register writes can be attempted.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int NUM_W = 24,
  parameter int NIRQ  = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sel,
  input  logic            cfg_we,
  input  logic [3:2]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            m_req,
  output logic            m_we,
  output logic [31:0]     m_addr,
  output logic [31:0]     m_wdata,
  output logic [3:0]      m_be,
  input  logic [31:0]     m_rdata,
  input  logic            m_ack,
  input  logic            m_err,
  input  logic [NIRQ-1:0] irq_i,
  output logic            fence_o
);
  localparam logic [31:0] TT_MASK = 32'hF800_0000 | 32'((64'd1 << NUM_W) - 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st_q;

  logic en_q, auto_q, fen_q, done_q, err_rd_q, err_wr_q;
  logic [NIRQ-1:0] mask_q, irq_q;
  logic [31:0] src_q, dst_q, ttype_q, data_q;
  logic [NUM_W-1:0] cnt_q;

  logic busy, wr_ctrl, wr_src, wr_dst, wr_type, start;
  logic [31:0] ttype_eff, conv;
  logic [7:0] rd_byte;
  logic [1:0] qsel;
  logic [2:0] rstep, wstep;

  assign busy    = st_q != S_IDLE;
  assign wr_ctrl = cfg_sel && cfg_we && cfg_addr == 2'd0;
  assign wr_src  = cfg_sel && cfg_we && cfg_addr == 2'd1 && !busy;
  assign wr_dst  = cfg_sel && cfg_we && cfg_addr == 2'd2 && !busy;
  assign wr_type = cfg_sel && cfg_we && cfg_addr == 2'd3 && !busy;

  assign ttype_eff = wr_type ? cfg_wdata : ttype_q;
  assign start = en_q && !busy &&
                 ((!auto_q && wr_type) || (auto_q && |(irq_i & ~irq_q & mask_q)));

  assign qsel  = ttype_q[28:27];
  assign rstep = (qsel == 2'b11) ? 3'd4 : 3'd1;
  assign wstep = (qsel == 2'b00) ? 3'd1 : 3'd4;

  assign rd_byte = m_rdata[8*src_q[1:0] +: 8];

  always_comb begin
    case (qsel)
      2'b10:   conv = {{24{rd_byte[7]}}, rd_byte};
      2'b11:   conv = m_rdata;
      default: conv = {24'd0, rd_byte};
    endcase
    if (ttype_q[31] && qsel != 2'b00)
      conv = {conv[7:0], conv[15:8], conv[23:16], conv[31:24]};
  end

  assign m_req   = busy;
  assign m_we    = st_q == S_WR;
  assign m_addr  = m_we ? dst_q : src_q;
  assign m_wdata = (qsel == 2'b00) ? {4{data_q[7:0]}} : data_q;
  assign m_be    = (qsel == 2'b00) ? (4'b0001 << dst_q[1:0]) : 4'b1111;

  always_comb begin
    case (cfg_addr)
      2'd0: cfg_rdata = {16'(mask_q), 4'd0, done_q, busy, err_wr_q, err_rd_q,
                         5'd0, fen_q, auto_q, en_q};
      2'd1: cfg_rdata = src_q;
      2'd2: cfg_rdata = dst_q;
      default: cfg_rdata = ttype_q & TT_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      en_q <= 1'b0; auto_q <= 1'b0; fen_q <= 1'b0;
      done_q <= 1'b0; err_rd_q <= 1'b0; err_wr_q <= 1'b0;
      mask_q <= '0; irq_q <= '0;
      src_q <= '0; dst_q <= '0; ttype_q <= '0; data_q <= '0;
      cnt_q <= '0; fence_o <= 1'b0;
    end else begin
      irq_q   <= irq_i;
      fence_o <= 1'b0;
      if (wr_ctrl) begin
        en_q   <= cfg_wdata[0];
        auto_q <= cfg_wdata[1];
        fen_q  <= cfg_wdata[2];
        mask_q <= cfg_wdata[16 +: NIRQ];
        if (!cfg_wdata[11]) begin
          done_q <= 1'b0; err_rd_q <= 1'b0; err_wr_q <= 1'b0;
        end
      end
      if (wr_src)  src_q   <= cfg_wdata;
      if (wr_dst)  dst_q   <= cfg_wdata;
      if (wr_type) ttype_q <= cfg_wdata;

      case (st_q)
        S_IDLE: if (start) begin
          err_rd_q <= 1'b0;
          err_wr_q <= 1'b0;
          if (ttype_eff[NUM_W-1:0] == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q <= 1'b0;
            cnt_q  <= ttype_eff[NUM_W-1:0];
            st_q   <= S_RD;
          end
        end
        S_RD: if (m_ack) begin
          data_q <= conv;
          if (ttype_q[29]) src_q <= src_q + 32'(rstep);
          st_q <= S_WR;
        end else if (m_err) begin
          err_rd_q <= 1'b1;
          done_q   <= 1'b1;
          st_q     <= S_IDLE;
        end
        S_WR: if (m_ack) begin
          if (ttype_q[30]) dst_q <= dst_q + 32'(wstep);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == NUM_W'(1)) begin
            st_q    <= S_IDLE;
            done_q  <= 1'b1;
            fence_o <= fen_q;
          end else begin
            st_q <= S_RD;
          end
        end else if (m_err) begin
          err_wr_q <= 1'b1;
          done_q   <= 1'b1;
          st_q     <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase

      if (wr_ctrl && !cfg_wdata[0]) st_q <= S_IDLE;
    end
  end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        m_req,
  input logic        m_we,
  input logic [31:0] m_addr,
  input logic        m_ack,
  input logic        m_err,
  input logic        fence_o,
  input logic        en_q,
  input logic        done_q,
  input logic        err_rd_q,
  input logic        err_wr_q
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !m_err) |=> (!en_q || (m_req && $stable(m_addr) && $stable(m_we))));

  a_r8_rd_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && m_err && !m_ack) |=> (!m_req && err_rd_q && done_q));

  a_r9_wr_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && m_err && !m_ack) |=> (!m_req && err_wr_q && done_q));

  a_r10_fence_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fence_o |-> $past(m_req && m_we && m_ack));

  a_r10_fence_single: assert property (@(posedge clk) disable iff (!rst_n)
    fence_o |=> !fence_o);

  a_r12_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !m_req);

  a_r11_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd_q || err_wr_q) |-> done_q);
endmodule

bind dma_engine dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
  .m_ack(m_ack), .m_err(m_err), .fence_o(fence_o), .en_q(en_q),
  .done_q(done_q), .err_rd_q(err_rd_q), .err_wr_q(err_wr_q)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;
  logic clk = 0, rst_n = 0;
  logic cfg_sel = 0, cfg_we = 0;
  logic [3:2] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic m_req, m_we, m_ack = 0, m_err = 0, fence_o;
  logic [31:0] m_addr, m_wdata, m_rdata = 0;
  logic [3:0] m_be;
  logic [15:0] irq_i = 0;

  always #5 clk = ~clk;

  dma_engine u0 (.clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err), .irq_i(irq_i), .fence_o(fence_o));

  int checks = 0, errors = 0, wr_acks = 0, fences = 0;
  bit finished = 0;
  logic [31:0] mem [256];
  logic [31:0] refm [256];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder: random latency, fault windows
  initial begin
    bit pend = 0;
    int dly = 0;
    forever begin
      @(negedge clk);
      m_ack = 0; m_err = 0;
      if (!m_req) pend = 0;
      else if (!pend) begin pend = 1; dly = int'($urandom % 3); end
      if (pend) begin
        if (dly == 0) begin
          pend = 0;
          if (m_we && m_addr[31:28] == 4'hE) m_err = 1;
          else if (!m_we && m_addr[31:28] == 4'hF) m_err = 1;
          else begin
            m_ack = 1;
            if (m_we) begin
              for (int b = 0; b < 4; b++)
                if (m_be[b]) mem[m_addr[9:2]][8*b +: 8] = m_wdata[8*b +: 8];
              wr_acks++;
            end else m_rdata = mem[m_addr[9:2]];
          end
        end else dly--;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (fence_o) fences++;
  end

  task automatic cfg_wr(input logic [3:2] a, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [3:2] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cfg_rd(0, c);
      if (!c[10]) return;
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [31:0] a);
    logic [31:0] w;
    w = refm[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  // reference transfer model from the requirements
  task automatic model(inout logic [31:0] s, inout logic [31:0] d, input logic [31:0] tt);
    logic [1:0] q;
    logic [7:0] b;
    logic [31:0] v;
    q = tt[28:27];
    for (int i = 0; i < int'(tt[23:0]); i++) begin
      b = ref_byte(s);
      case (q)
        2'b01: v = {24'd0, b};
        2'b10: v = {{24{b[7]}}, b};
        2'b11: v = refm[s[9:2]];
        default: v = {24'd0, b};
      endcase
      if (q == 2'b00) refm[d[9:2]][8*d[1:0] +: 8] = b;
      else begin
        if (tt[31]) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
        refm[d[9:2]] = v;
      end
      if (tt[29]) s = s + ((q == 2'b11) ? 32'd4 : 32'd1);
      if (tt[30]) d = d + ((q == 2'b00) ? 32'd1 : 32'd4);
    end
  endtask

  function automatic bit mem_match();
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, s, d, tt, se, de;
    int w0, f0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; refm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state and readback layout
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); cfg_rd(2'(a), r);
      chk(r == 0, "R1 reset", r, 0);
    end
    cfg_wr(0, 32'hABCD_0006);
    cfg_rd(0, r); chk(r == 32'hABCD_0006, "R1 ctrl", r, 32'hABCD_0006);
    cfg_wr(3, 32'hFFFF_FFFF);
    cfg_rd(3, r); chk(r == 32'hF8FF_FFFF, "R1 ttype", r, 32'hF8FF_FFFF);
    cfg_wr(1, 32'h1234_5678); cfg_rd(1, r); chk(r == 32'h1234_5678, "R1 src", r, 32'h1234_5678);
    cfg_wr(2, 32'h9ABC_DEF0); cfg_rd(2, r); chk(r == 32'h9ABC_DEF0, "R1 dst", r, 32'h9ABC_DEF0);

    // R2 disabled: descriptor write starts nothing
    cfg_wr(0, 0);
    cfg_wr(1, 0); cfg_wr(2, 32'h200); cfg_wr(3, 32'hE000_0002);
    repeat (5) @(negedge clk);
    cfg_rd(0, r); chk(r[11:10] == 0, "R2 disabled no start", r, 0);

    // R3 zero count
    cfg_wr(0, 1); w0 = wr_acks;
    cfg_wr(3, 32'hE000_0000);
    repeat (3) @(negedge clk);
    cfg_rd(0, r); chk(r[11:10] == 2'b10, "R3 zero count done", r, 32'h800);
    chk(wr_acks == w0, "R3 no access", 32'(wr_acks), 32'(w0));

    // R4 R5 R6 R10 random transfers
    for (int it = 0; it < 30; it++) begin
      logic [1:0] q;
      bit fe;
      q = 2'($urandom); fe = 1'($urandom);
      tt = {1'($urandom), 1'($urandom), 1'($urandom), q, 3'd0, 24'(1 + $urandom % 12)};
      s = 32'($urandom % 256); d = 32'(512 + $urandom % 256);
      if (q == 2'b11) s[1:0] = 0;
      if (q != 2'b00) d[1:0] = 0;
      se = s; de = d;
      model(se, de, tt);
      cfg_wr(0, fe ? 32'h5 : 32'h1);
      f0 = fences;
      cfg_wr(1, s); cfg_wr(2, d); cfg_wr(3, tt);
      cfg_rd(0, r); chk(r[10], "R2 busy after start", r, 32'h400);
      wait_idle(); repeat (2) @(negedge clk);
      chk(mem_match(), "R4 R6 memory", tt, 0);
      cfg_rd(1, r); chk(r == se, "R5 src end", r, se);
      cfg_rd(2, r); chk(r == de, "R5 dst end", r, de);
      cfg_rd(0, r); chk(r[11:8] == 4'b1000, "R3 done flags", r, 32'h800);
      chk(fences - f0 == (fe ? 1 : 0), "R10 fence count", 32'(fences - f0), fe ? 1 : 0);
    end

    // R6 directed: byte widen with swap, sign fill
    mem[0] = 32'h0000_9C00; refm[0] = mem[0];
    cfg_wr(1, 32'h1); cfg_wr(2, 32'h300); cfg_wr(3, 32'h9000_0001);
    wait_idle(); repeat (2) @(negedge clk);
    chk(mem[192] == 32'h9CFF_FFFF, "R6 R4 sign swap", mem[192], 32'h9CFF_FFFF);
    refm[192] = mem[192];

    // R7 auto mode
    cfg_wr(0, 32'h0008_0003);
    cfg_wr(1, 32'h10); cfg_wr(2, 32'h280); cfg_wr(3, 32'h7800_0003);
    repeat (3) @(negedge clk);
    cfg_rd(0, r); chk(r[11:10] == 0, "R7 descriptor write no start", r, 0);
    irq_i[5] = 1; repeat (4) @(negedge clk); irq_i[5] = 0;
    cfg_rd(0, r); chk(r[11:10] == 0, "R7 masked line", r, 0);
    se = 32'h10; de = 32'h280; model(se, de, 32'h7800_0003);
    irq_i[3] = 1;
    repeat (2) @(negedge clk);
    wait_idle(); repeat (2) @(negedge clk);
    chk(mem_match(), "R7 auto transfer", 0, 0);
    cfg_rd(0, r); chk(r[11], "R7 auto done", r, 32'h800);
    cfg_wr(0, 32'h0008_0003);
    repeat (6) @(negedge clk);
    cfg_rd(0, r); chk(r[11:10] == 0, "R7 held level no restart", r, 0);
    irq_i[3] = 0;

    // R8 read error mid transfer
    cfg_wr(0, 32'h5); f0 = fences; w0 = wr_acks;
    cfg_wr(1, 32'hEFFF_FFF8); cfg_wr(2, 32'h200); cfg_wr(3, 32'h7800_0004);
    wait_idle(); repeat (2) @(negedge clk);
    cfg_rd(0, r); chk(r[11:8] == 4'b1001, "R8 flags", r, 32'h900);
    cfg_rd(1, r); chk(r == 32'hF000_0000, "R8 src fault addr", r, 32'hF000_0000);
    cfg_rd(2, r); chk(r == 32'h208, "R8 dst", r, 32'h208);
    chk(wr_acks - w0 == 2, "R8 writes before error", 32'(wr_acks - w0), 2);
    chk(fences == f0, "R10 no fence on error", 32'(fences), 32'(f0));

    // R9 write error
    cfg_wr(1, 32'h40); cfg_wr(2, 32'hDFFF_FFFC); cfg_wr(3, 32'h7800_0003);
    wait_idle(); repeat (2) @(negedge clk);
    cfg_rd(0, r); chk(r[11:8] == 4'b1010, "R9 flags", r, 32'hA00);
    cfg_rd(2, r); chk(r == 32'hE000_0000, "R9 dst fault addr", r, 32'hE000_0000);
    cfg_rd(1, r); chk(r == 32'h48, "R9 src", r, 32'h48);
    chk(fences == f0, "R10 no fence on write error", 32'(fences), 32'(f0));

    // R11 clear semantics
    cfg_wr(0, 32'h0000_0801);
    cfg_rd(0, r); chk(r[11:8] == 4'b1010, "R11 bit11 set keeps", r, 32'hA00);
    cfg_wr(0, 32'h1);
    cfg_rd(0, r); chk(r[11:8] == 0, "R11 clear", r, 0);

    // R12 abort and R14 locked registers
    cfg_wr(1, 32'h20); cfg_wr(2, 32'h240); cfg_wr(3, 32'h1800_03E8);
    repeat (20) @(negedge clk);
    cfg_rd(0, r); chk(r[10], "R12 busy before abort", r, 32'h400);
    cfg_wr(1, 32'h123); cfg_wr(3, 32'h0000_0005);
    cfg_wr(0, 0);
    w0 = wr_acks;
    repeat (20) @(negedge clk);
    cfg_rd(0, r); chk(r[11:10] == 0, "R12 abort flags", r, 0);
    chk(wr_acks == w0, "R12 no access after abort", 32'(wr_acks), 32'(w0));
    cfg_rd(1, r); chk(r == 32'h20, "R14 src locked", r, 32'h20);
    cfg_rd(3, r); chk(r == 32'h1800_03E8, "R14 ttype locked", r, 32'h1800_03E8);
    // R13 checked by a_r13_req_hold during all traffic above

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule